// File: doc/BRIEF.md
# Write-Protected Preloadable Watchdog Timer

This block is a small watchdog for a larger chip. An upward counter advances once per tick of a fixed power-of-two clock divider. When a tick finds the counter at its top value, the counter wraps to zero and the block raises an internal reset output for a fixed number of clock cycles. Software sets the overflow period by writing a start value into the counter, and restarts the count by writing it again. Each write moves the counter away from overflow.

The control/status register guards its two meaningful bits. Each of them has a companion inhibit bit in the same byte, and a bit changes only in an access that writes its inhibit bit as 0. The run bit has a second guard: it changes only while the write-enable bit is already set. So starting the watchdog from reset takes two separate writes. The first sets write-enable. The second sets run. A single access that tries to set both only sets write-enable.

The register port is a single-cycle synchronous write with a combinational read. A one-bit address selects the control/status register or the counter.

Top module: `wdt_guard`

## Requirements
- R1: After reset the counter reads 0x00, the run and write-enable bits are 0, `wdt_rst_o` is low, and the control/status register reads 0x0A.
- R2: Address 0 selects the control/status register and address 1 selects the counter. The control/status bits are: bit 0 run, bit 1 run inhibit, bit 2 write-enable, bit 3 write-enable inhibit. Bits above 3 read 0, and both inhibit bits always read 1.
- R3: The write-enable bit takes the value of write-data bit 2 only in a control/status write whose bit 3 is 0. Otherwise it keeps its value.
- R4: The run bit takes the value of write-data bit 0 only in a control/status write whose bit 1 is 0, and only if write-enable was already 1 before that access. Setting write-enable and run in one access leaves run at 0.
- R5: The divider produces one tick every 2^DIV_W clock cycles. The tick falls on the edges numbered at multiples of 2^DIV_W, counting from the first edge after reset is released. While run is 1, each tick adds one to the counter. While run is 0, the counter holds.
- R6: A counter write loads the written value, which reads back at once. If a tick falls in the same cycle, the write wins and that tick is lost.
- R7: A tick that finds the counter at all ones, with run set, wraps the counter to 0x00 and raises `wdt_rst_o` from that edge. The counter keeps counting afterwards. After a preload of p the overflow comes on the (2^CNT_W - p)-th tick.
- R8: `wdt_rst_o` stays high for exactly RST_LEN cycles after the last overflow. An overflow during a pulse restarts the full width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, also the time base for the reset pulse |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe, one cycle per access |
| reg_addr | input | 1 | 0 = control/status, 1 = counter |
| reg_wdata | input | CNT_W | Write data |
| reg_rdata | output | CNT_W | Read data of the addressed register |
| wdt_rst_o | output | 1 | Internal reset pulse output |

## Verification
The assertions assume a write strobe lasts one cycle and that its address and data are settled before the edge. They also assume that no tick or overflow is meaningful before the first edge after reset release. The bench drives every input on the falling clock edge and holds each write for exactly one cycle. It works in a small configuration: a divide-by-4 tick with the full 256-cycle pulse. This keeps overflow periods short enough to sweep 67 preload values while still exercising the real pulse width. Two timing cases are placed deliberately: the priority write lands on a tick edge, and the retrigger write lands inside a running pulse.

// File: rtl/wdtg_pkg.sv
`timescale 1ns/1ps
package wdtg_pkg;
  localparam int CSR_RUN     = 0;
  localparam int CSR_RUN_NWR = 1;
  localparam int CSR_WEN     = 2;
  localparam int CSR_WEN_NWR = 3;

  typedef enum logic {
    SEL_CSR = 1'b0,
    SEL_CNT = 1'b1
  } wdtg_sel_e;

  // low nibble of the control/status read image; inhibit bits read as 1
  function automatic logic [3:0] csr_image(input logic run, input logic wen);
    logic [3:0] img;
    img              = 4'b0000;
    img[CSR_RUN]     = run;
    img[CSR_RUN_NWR] = 1'b1;
    img[CSR_WEN]     = wen;
    img[CSR_WEN_NWR] = 1'b1;
    return img;
  endfunction
endpackage

// File: rtl/wdtg_tick_div.sv
`timescale 1ns/1ps
module wdtg_tick_div #(
  parameter int DIV_W = 13
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  logic [DIV_W-1:0] div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_q + 1'b1;
  end

  assign tick = &div_q;
endmodule

// File: rtl/wdtg_ctrl.sv
`timescale 1ns/1ps
module wdtg_ctrl
  import wdtg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       csr_wr,
  input  logic [3:0] wbits,
  output logic       run,
  output logic       wen,
  output logic       run_upd,
  output logic       wen_upd
);
  assign wen_upd = csr_wr && !wbits[CSR_WEN_NWR];
  assign run_upd = csr_wr && !wbits[CSR_RUN_NWR] && wen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wen <= 1'b0;
      run <= 1'b0;
    end else begin
      if (wen_upd) wen <= wbits[CSR_WEN];
      if (run_upd) run <= wbits[CSR_RUN];
    end
  end
endmodule

// File: rtl/wdtg_counter.sv
`timescale 1ns/1ps
module wdtg_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             step,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf
);
  logic do_step;

  assign do_step = step && !load;
  assign ovf     = do_step && (cnt == {CNT_W{1'b1}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (load)    cnt <= load_val;
    else if (do_step) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/wdtg_rst_pulse.sv
`timescale 1ns/1ps
module wdtg_rst_pulse #(
  parameter int LEN = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic pulse
);
  localparam int PW = $clog2(LEN + 1);
  logic [PW-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            left <= '0;
    else if (fire)         left <= PW'(LEN);
    else if (left != '0)   left <= left - 1'b1;
  end

  assign pulse = (left != '0);
endmodule

// File: rtl/wdt_guard.sv
`timescale 1ns/1ps
module wdt_guard
  import wdtg_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int DIV_W   = 13,
  parameter int RST_LEN = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_addr,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic [CNT_W-1:0] reg_rdata,
  output logic             wdt_rst_o
);
  logic             csr_wr, cnt_wr;
  logic             tick, step, ovf;
  logic             run, wen, run_upd, wen_upd;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] csr_rd;

  assign csr_wr = reg_wr && (reg_addr == SEL_CSR);
  assign cnt_wr = reg_wr && (reg_addr == SEL_CNT);
  assign step   = tick && run;

  wdtg_tick_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  wdtg_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .wbits(reg_wdata[3:0]),
    .run(run), .wen(wen), .run_upd(run_upd), .wen_upd(wen_upd)
  );

  wdtg_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(cnt_wr), .load_val(reg_wdata),
    .step(step), .cnt(cnt), .ovf(ovf)
  );

  wdtg_rst_pulse #(.LEN(RST_LEN)) u_pulse (
    .clk(clk), .rst_n(rst_n), .fire(ovf), .pulse(wdt_rst_o)
  );

  always_comb begin
    csr_rd      = '0;
    csr_rd[3:0] = csr_image(run, wen);
  end

  assign reg_rdata = (reg_addr == SEL_CNT) ? cnt : csr_rd;
endmodule

// File: rtl/wdt_guard_chk.sv
`timescale 1ns/1ps
module wdt_guard_chk #(
  parameter int CNT_W   = 8,
  parameter int RST_LEN = 256
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic             reg_addr,
  input logic [CNT_W-1:0] reg_wdata,
  input logic [CNT_W-1:0] reg_rdata,
  input logic             wdt_rst_o,
  input logic             tick,
  input logic             run,
  input logic             wen,
  input logic             ovf,
  input logic [CNT_W-1:0] cnt
);
  localparam int HW = $clog2(RST_LEN + 1) + 1;
  logic [HW-1:0] hi_cnt;

  // consecutive high cycles of the pulse since the latest overflow
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         hi_cnt <= '0;
    else if (ovf)       hi_cnt <= '0;
    else if (wdt_rst_o) hi_cnt <= hi_cnt + 1'b1;
  end

  AST_CSR_IMAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 1'b0) |-> (reg_rdata[3] && reg_rdata[1] && (reg_rdata >> 4) == '0)); // R2

  AST_WEN_GUARDED: assert property (@(posedge clk) disable iff (!rst_n)
    (wen != $past(wen)) |-> $past(reg_wr && !reg_addr && !reg_wdata[3])); // R3

  AST_RUN_NEEDS_WEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> ($past(wen) && $past(reg_wr && !reg_addr && !reg_wdata[1]))); // R4

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && run && !(reg_wr && reg_addr)) |=> (cnt == CNT_W'($past(cnt) + 1'b1))); // R5

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!(tick && run) && !(reg_wr && reg_addr)) |=> $stable(cnt)); // R5

  AST_CNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr) |=> (cnt == $past(reg_wdata))); // R6

  AST_OVF_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> (wdt_rst_o && cnt == '0)); // R7

  AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wdt_rst_o) |-> (hi_cnt == HW'(RST_LEN))); // R8
endmodule

bind wdt_guard wdt_guard_chk #(.CNT_W(CNT_W), .RST_LEN(RST_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .wdt_rst_o(wdt_rst_o),
  .tick(tick), .run(run), .wen(wen), .ovf(ovf), .cnt(cnt)
);

// File: tb/wdt_guard_bench.sv
`timescale 1ns/1ps
module wdt_guard_bench;
  localparam int CNT_W   = 8;
  localparam int DIV_W   = 2;
  localparam int RST_LEN = 256;
  localparam int DIVP    = 1 << DIV_W;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             reg_wr = 1'b0;
  logic             reg_addr = 1'b0;
  logic [CNT_W-1:0] reg_wdata = '0;
  logic [CNT_W-1:0] reg_rdata;
  logic             wdt_rst_o;

  int vectors = 0;
  int fails   = 0;
  int e       = 0;   // edges since reset release
  bit done    = 0;

  wdt_guard #(.CNT_W(CNT_W), .DIV_W(DIV_W), .RST_LEN(RST_LEN)) u_wdt_guard (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .wdt_rst_o(wdt_rst_o)
  );

  always #4 clk = ~clk;   // 125 MHz

  always @(posedge clk) if (rst_n) e <= e + 1;

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h (edge %0d)", tag, act, exp, e);
    end
  endtask

  // called right after a falling edge; the write lands on the next rising edge
  task automatic wr(input logic a, input logic [CNT_W-1:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic peek(input logic a, output int d);
    reg_addr = a;
    #1;
    d = int'(reg_rdata);
  endtask

  // ticks on edges x with lo < x <= hi
  function automatic int ticks(input int lo, input int hi);
    return hi / DIVP - lo / DIVP;
  endfunction

  int v;

  task automatic run_trial(input int p, input bit retrig);
    int ew, rise_e, exp_rise, fall_e, exp_fall, guard;
    wr(1'b0, 8'h08);                 // stop, keep write-enable
    wr(1'b1, p[CNT_W-1:0]);
    wr(1'b0, 8'h09);                 // run on
    ew = e;
    exp_rise = (ew / DIVP + 1) * DIVP + DIVP * (255 - p);
    guard = 0;
    while (!wdt_rst_o && guard < 3000) begin @(negedge clk); guard++; end
    rise_e = e;
    chk($sformatf("R7 overflow edge p=0x%0h", p), rise_e, exp_rise);
    peek(1'b1, v);
    chk($sformatf("R7 wrap to zero p=0x%0h", p), v, 0);
    exp_fall = rise_e + RST_LEN;
    if (retrig) begin
      repeat (100) @(negedge clk);
      wr(1'b1, 8'hFF);
      exp_fall = (e / DIVP + 1) * DIVP + RST_LEN;
    end
    guard = 0;
    while (wdt_rst_o && guard < 3000) begin @(negedge clk); guard++; end
    fall_e = e;
    chk($sformatf("R8 pulse end p=0x%0h retrig=%0d", p, retrig), fall_e, exp_fall);
  endtask

  initial begin
    int ew, base, base_e;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    peek(1'b0, v); chk("R1 csr after reset", v, 8'h0A);
    peek(1'b1, v); chk("R1 counter after reset", v, 0);
    chk("R1 reset output low", int'(wdt_rst_o), 0);

    // R4 single access cannot start; sets write-enable only
    wr(1'b0, 8'h05);
    peek(1'b0, v); chk("R4 one-access start refused", v, 8'h0E);
    repeat (20) @(negedge clk);
    peek(1'b1, v); chk("R5 counter holds while stopped", v, 0);

    // R3 write-enable inhibit
    wr(1'b0, 8'h08);
    peek(1'b0, v); chk("R3 wen kept under inhibit", v, 8'h0E);
    // R4 run inhibit
    wr(1'b0, 8'h0B);
    peek(1'b0, v); chk("R4 run kept under inhibit", v, 8'h0E);
    // R3 clear write-enable
    wr(1'b0, 8'h00);
    peek(1'b0, v); chk("R3 wen cleared", v, 8'h0A);
    // R4 run refused with write-enable 0
    wr(1'b0, 8'h09);
    peek(1'b0, v); chk("R4 run refused without wen", v, 8'h0A);
    wr(1'b0, 8'h04);
    peek(1'b0, v); chk("R3 wen set", v, 8'h0E);
    wr(1'b0, 8'h09);
    peek(1'b0, v); chk("R4 second access starts", v, 8'h0F);
    wr(1'b0, 8'h08);
    peek(1'b0, v); chk("R4 stop", v, 8'h0E);
    peek(1'b1, v); base = v;
    repeat (12) @(negedge clk);
    peek(1'b1, v); chk("R5 frozen after stop", v, base);

    // R6 preload
    wr(1'b1, 8'h5A);
    peek(1'b1, v); chk("R6 preload readback", v, 8'h5A);
    repeat (12) @(negedge clk);
    peek(1'b1, v); chk("R6 preload held while stopped", v, 8'h5A);

    // R5 stepping on multiples of DIVP
    wr(1'b0, 8'h09);
    base = 8'h5A; base_e = e;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      peek(1'b1, v);
      chk("R5 step timing", v, (base + ticks(base_e, e)) % 256);
    end

    // R6 write on a tick edge wins
    while ((e % DIVP) != DIVP - 1) @(negedge clk);
    wr(1'b1, 8'h30);
    base = 8'h30; base_e = e;
    chk("R6 write edge is a tick edge", e % DIVP, 0);
    for (int i = 0; i < 12; i++) begin
      peek(1'b1, v);
      chk("R6 priority over tick", v, (base + ticks(base_e, e)) % 256);
      @(negedge clk);
    end

    // R7 / R8 sweep of preloads
    for (int p = 8'hFF; p >= 8'hC0; p--) run_trial(p, 1'b0);
    run_trial(8'hF1, 1'b0);
    run_trial(8'h80, 1'b0);
    run_trial(8'h00, 1'b0);
    // R8 retrigger during pulse
    run_trial(8'hFE, 1'b1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      vectors++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule